// File: doc/BRIEF.md
# Pre-Connection Line Wiggle Gate

This block stands between a channel-select register and the switches that join downstream two-wire channels to the host bus. A channel that is newly selected is not connected at once. The block first checks that both of the channel's open-drain lines can actually be pulled low. Only a channel that passes this check is joined to the host.

The check waits until a stop condition has been seen after the select write. Channels are then tested one after another, from the lowest index upwards. For each channel the block pulls the clock line low, then the data line low, and reads back both lines. It then lets go of the clock line and after that the data line, which leaves a stop condition on the downstream bus.

A channel that fails stays disconnected. Its bit is set in a fault register, and an interrupt request can be raised. Reading the fault register clears it. Channels that are already connected are never retested. Host protocol decoding lies outside this block: it receives a select-write strobe, a stop strobe and a fault-read strobe.

Top module: `line_wiggle_gate`

## Requirements
- R1: While `cfg_test_en` is 0, a select write makes `conn_mask` equal to the written value on the next cycle, with no line pulled.
- R2: While `cfg_test_en` is 1, a channel whose select bit goes from 0 to 1 is neither connected nor pulled until `stop_seen` has pulsed. A channel that is already connected stays connected through later writes that keep its bit set.
- R3: A test on channel i lasts 4*SETTLE cycles and has four phases of SETTLE cycles each. Written as {scl_pull[i], sda_pull[i]}, the phases are 2'b10, 2'b11, 2'b01 and 2'b00, in that order. The sense lines are sampled in the last cycle of the 2'b11 phase.
- R4: At most one channel is pulled at any time. Channels that are armed together are tested in ascending index order.
- R5: A channel that reads both lines low is added to `conn_mask` on the edge that ends its last phase. A channel that sees either line high is left unconnected, and its bit is set in `fault_reg` on that same edge.
- R6: `irq_req` is 1 exactly one cycle after a cycle in which `cfg_irq_en` was 1, `cfg_test_en` was 1 and the fault register (after that cycle's update) was non-zero.
- R7: A `fault_rd` pulse clears `fault_reg` on the next edge. A fault recorded in the same cycle as the read is kept.
- R8: Setting `cfg_test_en` to 0 abandons any running test, clears `fault_reg` and connects every selected channel on the next edge.
- R9: If a write deselects the channel under test, the test stops. No pull is active on the next cycle, and the channel is neither recorded as a fault nor connected.
- R10: A write that clears a select bit clears the matching `conn_mask` bit on the next edge.
- R11: After a synchronous active-low reset, `conn_mask`, `fault_reg`, `irq_req` and all pulls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_test_en | input | 1 | Enables pre-connection testing |
| cfg_irq_en | input | 1 | Enables interrupt notification |
| sel_wr | input | 1 | Select register write strobe |
| sel_wdata | input | NCH | Value written to the select register |
| stop_seen | input | 1 | Strobe: stop condition seen on host bus |
| fault_rd | input | 1 | Strobe: fault register is being read |
| scl_sense | input | NCH | Sensed clock level per channel |
| sda_sense | input | NCH | Sensed data level per channel |
| scl_pull | output | NCH | Pull channel clock line low |
| sda_pull | output | NCH | Pull channel data line low |
| conn_mask | output | NCH | Channels joined to the host bus |
| fault_reg | output | NCH | Channels that failed their test |
| irq_req | output | 1 | Interrupt request, active high |

## Verification
Two events can land in the same cycle. The first is recording a failed test in the last cycle of a channel's final phase. The second is a `fault_rd` pulse that clears the register. The bench provokes this by arming two stuck channels and pulsing the read exactly in the last cycle of the second channel's test. It then expects only the second channel's bit to remain. A second race puts a deselect write in the middle of a running test, and the bench checks that no fault bit and no connection follow from it.

// File: rtl/wg_pkg.sv
// Shared types for the line wiggle gate.
package wg_pkg;
    // Phases of one channel test; order is the drive/release order.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CLK_LO  = 3'd1,
        PH_BOTH_LO = 3'd2,
        PH_CLK_REL = 3'd3,
        PH_DAT_REL = 3'd4
    } phase_t;
endpackage

// File: rtl/wg_select_track.sv
// Select/arm/connect bookkeeping.
// Holds the select register, channels waiting for a stop, channels armed
// for test, and the connect mask. Assumes at most one pass result per cycle.
module wg_select_track #(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_en,
    input  logic           sel_wr,
    input  logic [NCH-1:0] sel_wdata,
    input  logic           stop_seen,
    input  logic           take_valid,
    input  logic [IW-1:0]  take_idx,
    input  logic           pass_valid,
    input  logic [IW-1:0]  pass_idx,
    output logic [NCH-1:0] sel_live,
    output logic [NCH-1:0] queue,
    output logic [NCH-1:0] conn
);
    logic [NCH-1:0] sel_q, pend_q, new_bits, take_mask, pass_mask;

    // Select value as it will be after this cycle.
    always_comb begin
        sel_live  = sel_wr ? sel_wdata : sel_q;
        new_bits  = sel_wr ? (sel_wdata & ~sel_q) : '0;
        take_mask = take_valid ? (NCH'(1) << take_idx) : '0;
        pass_mask = pass_valid ? (NCH'(1) << pass_idx) : '0;
    end

    // Register update for select, pending, armed and connected sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            pend_q <= '0;
            queue  <= '0;
            conn   <= '0;
        end else if (!test_en) begin
            sel_q  <= sel_live;
            pend_q <= '0;
            queue  <= '0;
            conn   <= sel_live;
        end else begin
            sel_q  <= sel_live;
            pend_q <= stop_seen ? '0 : ((pend_q | new_bits) & sel_live);
            queue  <= ((queue & ~take_mask) |
                       (stop_seen ? (pend_q | new_bits) : '0)) & sel_live;
            conn   <= (conn | pass_mask) & sel_live;
        end
    end

    // R2: with testing on, a channel only joins through a pass result
    p_join_by_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && $past(test_en) && $past(rst_n)) |->
            ((conn & ~$past(conn) & ~$past(pass_mask)) == '0));

    // R10: a cleared select bit drops the connection next cycle
    p_deselect_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> ((conn & ~$past(sel_wdata)) == '0));
endmodule

// File: rtl/wg_sequencer.sv
// Per-channel wiggle test sequencer.
// Picks the lowest armed channel, runs four SETTLE-cycle phases, samples the
// sense lines at the end of the both-low phase and reports pass or fail.
// Assumes sense inputs are already synchronised.
module wg_sequencer
    import wg_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int SETTLE = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_en,
    input  logic [NCH-1:0] queue,
    input  logic [NCH-1:0] sel_live,
    input  logic [NCH-1:0] scl_sense,
    input  logic [NCH-1:0] sda_sense,
    output logic           take_valid,
    output logic [IW-1:0]  take_idx,
    output logic           done_valid,
    output logic           done_pass,
    output logic [IW-1:0]  done_idx,
    output logic [NCH-1:0] scl_pull,
    output logic [NCH-1:0] sda_pull
);
    phase_t         phase;
    logic [CW-1:0]  cnt;
    logic [IW-1:0]  cur;
    logic           pass_q;
    logic           live, last;

    // Lowest armed channel index.
    always_comb begin
        take_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (queue[i]) take_idx = IW'(i);
        end
    end

    // Phase-step and completion decode.
    always_comb begin
        live       = test_en && sel_live[cur];
        last       = (cnt == CW'(SETTLE - 1));
        take_valid = (phase == PH_IDLE) && test_en && (|queue);
        done_valid = (phase == PH_DAT_REL) && last && live;
        done_pass  = pass_q;
        done_idx   = cur;
    end

    // Line pull decode for the channel under test.
    for (genvar g = 0; g < NCH; g++) begin : g_pull
        assign scl_pull[g] = (cur == IW'(g)) &&
                             ((phase == PH_CLK_LO) || (phase == PH_BOTH_LO));
        assign sda_pull[g] = (cur == IW'(g)) &&
                             ((phase == PH_BOTH_LO) || (phase == PH_CLK_REL));
    end

    // Phase machine with settle counter and sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            cur    <= '0;
            pass_q <= 1'b0;
        end else if (phase == PH_IDLE) begin
            cnt <= '0;
            if (take_valid) begin
                cur   <= take_idx;
                phase <= PH_CLK_LO;
            end
        end else if (!live) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else if (!last) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
            case (phase)
                PH_CLK_LO:  phase <= PH_BOTH_LO;
                PH_BOTH_LO: begin
                    phase  <= PH_CLK_REL;
                    pass_q <= !scl_sense[cur] && !sda_sense[cur];
                end
                PH_CLK_REL: phase <= PH_DAT_REL;
                default:    phase <= PH_IDLE;
            endcase
        end
    end

    // R3: clock released before data at the end of the both-low phase
    p_release_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BOTH_LO && last && live) |=>
            (scl_pull == '0 && sda_pull != '0));

    // R9: abandoned test leaves no pull on the next cycle
    p_abandon_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && !live) |=> ((scl_pull | sda_pull) == '0));
endmodule

// File: rtl/wg_fault_log.sv
// Fault register and interrupt request.
// Sets a bit per failed channel, clears on read or test disable; a fault
// recorded in the same cycle as a read is kept.
module wg_fault_log #(
    parameter int NCH = 8,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_en,
    input  logic           irq_en,
    input  logic           rec_valid,
    input  logic [IW-1:0]  rec_idx,
    input  logic           rd,
    output logic [NCH-1:0] fault,
    output logic           irq
);
    logic [NCH-1:0] fault_n;

    // Next fault value: read clears old bits, new record survives.
    always_comb begin
        fault_n = (rd ? '0 : fault) | (rec_valid ? (NCH'(1) << rec_idx) : '0);
        if (!test_en) fault_n = '0;
    end

    // Fault and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= '0;
            irq   <= 1'b0;
        end else begin
            fault <= fault_n;
            irq   <= irq_en && test_en && (|fault_n);
        end
    end

    // R7: a read without a new record empties the register
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !rec_valid) |=> (fault == '0));

    // R8: disabling the test empties the register
    p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> (fault == '0));

    // R5: a recorded failure is visible next cycle
    p_record_seen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && test_en) |=> (fault != '0));

    // R6: request only follows an enabled cycle
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(irq_en) && $past(test_en)));
endmodule

// File: rtl/line_wiggle_gate.sv
// Top of the pre-connection line wiggle gate.
// Gates downstream channel connection on a pull-low-and-verify test run
// after a stop condition. Assumes strobes are single-cycle and sense
// inputs are synchronised to clk.
module line_wiggle_gate #(
    parameter int NCH    = 8,
    parameter int SETTLE = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_test_en,
    input  logic           cfg_irq_en,
    input  logic           sel_wr,
    input  logic [NCH-1:0] sel_wdata,
    input  logic           stop_seen,
    input  logic           fault_rd,
    input  logic [NCH-1:0] scl_sense,
    input  logic [NCH-1:0] sda_sense,
    output logic [NCH-1:0] scl_pull,
    output logic [NCH-1:0] sda_pull,
    output logic [NCH-1:0] conn_mask,
    output logic [NCH-1:0] fault_reg,
    output logic           irq_req
);
    logic [NCH-1:0] sel_live, queue;
    logic           take_valid, done_valid, done_pass;
    logic [IW-1:0]  take_idx, done_idx;

    wg_select_track #(.NCH(NCH)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (cfg_test_en),
        .sel_wr     (sel_wr),
        .sel_wdata  (sel_wdata),
        .stop_seen  (stop_seen),
        .take_valid (take_valid),
        .take_idx   (take_idx),
        .pass_valid (done_valid && done_pass),
        .pass_idx   (done_idx),
        .sel_live   (sel_live),
        .queue      (queue),
        .conn       (conn_mask)
    );

    wg_sequencer #(.NCH(NCH), .SETTLE(SETTLE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (cfg_test_en),
        .queue      (queue),
        .sel_live   (sel_live),
        .scl_sense  (scl_sense),
        .sda_sense  (sda_sense),
        .take_valid (take_valid),
        .take_idx   (take_idx),
        .done_valid (done_valid),
        .done_pass  (done_pass),
        .done_idx   (done_idx),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull)
    );

    wg_fault_log #(.NCH(NCH)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .test_en   (cfg_test_en),
        .irq_en    (cfg_irq_en),
        .rec_valid (done_valid && !done_pass),
        .rec_idx   (done_idx),
        .rd        (fault_rd),
        .fault     (fault_reg),
        .irq       (irq_req)
    );

    // R4: never more than one channel pulled
    p_single_channel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scl_pull | sda_pull));
endmodule

// File: tb/line_wiggle_gate_bench.sv
// Self-checking bench for line_wiggle_gate.
module line_wiggle_gate_bench;
    localparam int NCH = 8;
    localparam int S   = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_test_en = 1'b0, cfg_irq_en = 1'b0;
    logic           sel_wr = 1'b0, stop_seen = 1'b0, fault_rd = 1'b0;
    logic [NCH-1:0] sel_wdata = '0;
    logic [NCH-1:0] stuck_scl = '0, stuck_sda = '0;
    logic [NCH-1:0] scl_sense, sda_sense, scl_pull, sda_pull;
    logic [NCH-1:0] conn_mask, fault_reg;
    logic           irq_req;

    int errors = 0, checks = 0, cycles = 0;

    always #2 clk = ~clk;

    // Open-drain line model: pulled low unless stuck high.
    assign scl_sense = ~scl_pull | stuck_scl;
    assign sda_sense = ~sda_pull | stuck_sda;

    line_wiggle_gate #(.NCH(NCH), .SETTLE(S)) u_line_wiggle_gate (
        .clk(clk), .rst_n(rst_n), .cfg_test_en(cfg_test_en),
        .cfg_irq_en(cfg_irq_en), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .stop_seen(stop_seen), .fault_rd(fault_rd), .scl_sense(scl_sense),
        .sda_sense(sda_sense), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .conn_mask(conn_mask), .fault_reg(fault_reg), .irq_req(irq_req));

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pop(input logic [NCH-1:0] v);
        int n = 0;
        for (int i = 0; i < NCH; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_sel(input logic [NCH-1:0] v);
        sel_wdata = v; sel_wr = 1'b1;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
    endtask

    task automatic pulse_rd();
        fault_rd = 1'b1;
        @(negedge clk);
        fault_rd = 1'b0;
    endtask

    // Wait until channel ch starts being pulled; returns 1 if seen.
    task automatic wait_pull(input int ch, output bit seen);
        seen = 1'b0;
        for (int t = 0; t < 200; t++) begin
            if (scl_pull[ch]) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    // Follow one test of channel ch from its first pulled cycle (R3, R5);
    // optionally pulse fault_rd in the final cycle.
    task automatic follow(input int ch, input bit pass_exp, input bit rd_last);
        for (int k = 0; k < 4 * S; k++) begin
            logic [1:0] exp_code;
            case (k / S)
                0: exp_code = 2'b10;
                1: exp_code = 2'b11;
                2: exp_code = 2'b01;
                default: exp_code = 2'b00;
            endcase
            chk("R3 phase code", {30'd0, scl_pull[ch], sda_pull[ch]},
                {30'd0, exp_code});
            if (k == 4 * S - 1) begin
                chk("R5 not joined before end", {31'd0, conn_mask[ch]}, 32'd0);
                if (rd_last) fault_rd = 1'b1;
            end
            @(negedge clk);
            fault_rd = 1'b0;
        end
        chk("R5 joined iff pass", {31'd0, conn_mask[ch]}, {31'd0, pass_exp});
        chk("R5 fault iff fail", {31'd0, fault_reg[ch]}, {31'd0, !pass_exp});
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit seen;
        logic [NCH-1:0] sel_m, conn_m, fault_m, nw, bad;
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);

        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R11 reset state
        chk("R11 conn", 32'(conn_mask), 0);
        chk("R11 fault", 32'(fault_reg), 0);
        chk("R11 irq", {31'd0, irq_req}, 0);
        chk("R11 pulls", 32'(scl_pull | sda_pull), 0);

        // R1 test disabled: direct connect
        write_sel(8'h05);
        chk("R1 direct connect", 32'(conn_mask), 32'h05);
        chk("R1 no pull", 32'(scl_pull | sda_pull), 0);
        // R10 deselect
        write_sel(8'h01);
        chk("R10 deselect drops", 32'(conn_mask), 32'h01);

        // R2 gate on stop
        cfg_test_en = 1'b1;
        stuck_sda[3] = 1'b1;
        write_sel(8'h0B);
        tick(6);
        chk("R2 not joined before stop", 32'(conn_mask), 32'h01);
        chk("R2 no pull before stop", 32'(scl_pull | sda_pull), 0);
        pulse_stop();
        wait_pull(1, seen);
        chk("R2 test started after stop", {31'd0, seen}, 1);
        chk("R4 one channel pulled", pop(scl_pull | sda_pull), 1);
        follow(1, 1'b1, 1'b0);
        // R4 ascending: channel 3 next
        tick(1);
        chk("R4 next is ch3", 32'(scl_pull), 32'h08);
        follow(3, 1'b0, 1'b0);
        chk("R2 prior connection kept", {31'd0, conn_mask[0]}, 1);
        chk("R5 conn after batch", 32'(conn_mask), 32'h03);
        chk("R6 irq off when disabled", {31'd0, irq_req}, 0);
        cfg_irq_en = 1'b1;
        tick(1);
        chk("R6 irq raised", {31'd0, irq_req}, 1);
        pulse_rd();
        chk("R7 read clears", 32'(fault_reg), 0);
        tick(1);
        chk("R6 irq drops after read", {31'd0, irq_req}, 0);

        // R9 deselect during test
        write_sel(8'h13);
        pulse_stop();
        wait_pull(4, seen);
        tick(S + 1);
        write_sel(8'h03);
        chk("R9 pulls stop", 32'(scl_pull | sda_pull), 0);
        tick(5 * S);
        chk("R9 no fault", 32'(fault_reg), 0);
        chk("R9 not joined", 32'(conn_mask), 32'h03);

        // R7 read collides with a new record
        stuck_scl[5] = 1'b1; stuck_sda[6] = 1'b1;
        write_sel(8'h63);
        pulse_stop();
        wait_pull(5, seen);
        follow(5, 1'b0, 1'b0);
        wait_pull(6, seen);
        follow(6, 1'b0, 1'b1);
        chk("R7 same-cycle record kept", 32'(fault_reg), 32'h40);

        // R8 disable mid-test
        write_sel(8'hF3);
        pulse_stop();
        wait_pull(4, seen);
        tick(2);
        cfg_test_en = 1'b0;
        tick(1);
        chk("R8 all selected joined", 32'(conn_mask), 32'hF3);
        chk("R8 fault cleared", 32'(fault_reg), 0);
        chk("R8 pulls stop", 32'(scl_pull | sda_pull), 0);

        // Random phase against a bench model
        write_sel(8'h00);
        cfg_test_en = 1'b1;
        tick(2);
        sel_m = '0; conn_m = '0; fault_m = '0;
        for (int it = 0; it < 60; it++) begin
            logic [NCH-1:0] wv;
            wv = NCH'($urandom);
            stuck_scl = NCH'($urandom) & NCH'($urandom);
            stuck_sda = NCH'($urandom) & NCH'($urandom);
            cfg_irq_en = 1'($urandom);
            nw = wv & ~sel_m;
            bad = nw & (stuck_scl | stuck_sda);
            write_sel(wv);
            pulse_stop();
            tick(pop(nw) * (4 * S + 1) + 4);
            sel_m = wv;
            conn_m = (conn_m & wv) | (nw & ~bad);
            fault_m = fault_m | bad;
            chk("R5 random conn", 32'(conn_mask), 32'(conn_m));
            chk("R5 random fault", 32'(fault_reg), 32'(fault_m));
            chk("R6 random irq", {31'd0, irq_req},
                {31'd0, cfg_irq_en && (fault_m != '0)});
            if ($urandom_range(0, 2) == 0) begin
                pulse_rd();
                fault_m = '0;
                chk("R7 random read", 32'(fault_reg), 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule